// File: doc/BRIEF.md
# Serial Port Interrupt Prioritizer

This block collects every interrupt cause of a 16550-style serial port and turns them into one interrupt request line plus a 4-bit identification code naming the most urgent cause. The causes are receiver line errors, received data (data-ready in byte mode, trigger level in FIFO mode), a receive character time-out, transmitter empty, modem status changes, and two DMA terminal-count events, one for each direction. Every cause has its own enable. A single master gate, driven from the modem control register, must be set before the request line can go high.

The datapath supplies one-cycle event pulses for the sticky causes and levels for the others. Read and write strobes clear the causes. The sticky status flags of the line, modem and terminal-count groups are always visible on output ports, whatever the enables and the master gate are set to. The ID code and the request line come from registers. They follow any change in pending state, in the enables or in the master gate one clock later.

Top module: `uart_irq_prioritizer`

## Requirements
- R1: After reset, `irq` is 0, `irq_id` is 4'b0001 (bit 0 set means nothing pending), and all status flags are 0.
- R2: `irq` is 1 only when `master_en` is 1 and at least one enabled cause is pending; clearing `master_en` forces `irq` low but leaves `irq_id` reporting.
- R3: Status flags capture their events whatever the enables and `master_en` are set to.
- R4: With several enabled causes pending, `irq_id` reports only the most urgent one, in this order from highest to lowest: line status 4'b0110, received data 4'b0100, time-out 4'b1100, transmitter empty 4'b0010, modem status 4'b0000, receive terminal count 4'b1000, transmit terminal count 4'b1010.
- R5: The time-out cause has no enable of its own and is gated by `en_rx_data`.
- R6: Line status is the OR of four sticky flags: `line_flags[0]` overrun, `[1]` parity, `[2]` framing, `[3]` break. A `rd_line` pulse clears all four, but an event in the same cycle still sets its flag.
- R7: Modem status is the OR of four sticky flags: `modem_flags[0]` clear-to-send change, `[1]` data-set-ready change, `[2]` ring trailing edge, `[3]` carrier-detect change. A `rd_modem` pulse clears them.
- R8: Terminal-count flags are `tc_flags[0]` receive and `tc_flags[1]` transmit. They have their own enables, and writing with `tc_wr` clears exactly the bits set in `tc_clr`.
- R9: With `fifo_mode` 0 the received-data cause is `rx_ready` and `rx_level_hit` is ignored. With `fifo_mode` 1 it is `rx_level_hit`, `rx_ready` is ignored, and only this mode allows the time-out.
- R10: Transmitter empty is pending from a rising edge of `tx_empty`. It is cleared by `wr_tx`, or by `rd_id` while `irq_id` shows 4'b0010.
- R11: In FIFO mode with the receive FIFO non-empty, the time-out sets after CHAR_CYCLES*TO_CHARS consecutive clocks without `rx_char_in` or `rd_rx`, and `rd_rx` clears it.
- R12: `irq` and `irq_id` change exactly one clock after the pending state, an enable or `master_en` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 = FIFO (16550) mode, 0 = byte (16450) mode |
| master_en | input | 1 | Master interrupt gate |
| en_line | input | 1 | Enable line status cause |
| en_rx_data | input | 1 | Enable received data and time-out causes |
| en_tx_empty | input | 1 | Enable transmitter empty cause |
| en_modem | input | 1 | Enable modem status cause |
| en_rx_tc | input | 1 | Enable receive terminal count |
| en_tx_tc | input | 1 | Enable transmit terminal count |
| ln_break | input | 1 | Break detected pulse |
| ln_frame | input | 1 | Framing error pulse |
| ln_parity | input | 1 | Parity error pulse |
| ln_overrun | input | 1 | Overrun error pulse |
| ms_dcd | input | 1 | Carrier-detect change pulse |
| ms_teri | input | 1 | Ring trailing-edge pulse |
| ms_dsr | input | 1 | Data-set-ready change pulse |
| ms_cts | input | 1 | Clear-to-send change pulse |
| rd_line | input | 1 | Line status register read strobe |
| rd_modem | input | 1 | Modem status register read strobe |
| rx_ready | input | 1 | Receive holding register full (byte mode) |
| rx_level_hit | input | 1 | Receive FIFO at trigger level (FIFO mode) |
| rx_fifo_nonempty | input | 1 | Receive FIFO holds data |
| rx_char_in | input | 1 | Character received pulse |
| rd_rx | input | 1 | Received data read strobe |
| tx_empty | input | 1 | Transmit holding register or FIFO empty |
| wr_tx | input | 1 | Transmit holding register write strobe |
| rd_id | input | 1 | ID register read strobe |
| tc_rx_ev | input | 1 | Receive DMA terminal count pulse |
| tc_tx_ev | input | 1 | Transmit DMA terminal count pulse |
| tc_wr | input | 1 | Terminal-count status write strobe |
| tc_clr | input | 2 | Write-1-to-clear mask for tc_flags |
| irq | output | 1 | Interrupt request |
| irq_id | output | 4 | Identification code of the top cause |
| line_flags | output | 4 | Sticky line status flags |
| modem_flags | output | 4 | Sticky modem status flags |
| tc_flags | output | 2 | Sticky terminal-count flags |

## Verification
An event pulse shows on its status flag one edge after the strobe, and on `irq_id` and `irq` one edge after that. Level causes, enables and `master_en` reach `irq_id` or `irq` after a single edge. The time-out flag rises on the CHAR_CYCLES*TO_CHARS-th idle edge and reaches `irq_id` on the following edge. The bench drives inputs and samples outputs on falling edges. A behavioural model advances on each rising edge with the same register count, so every comparison falls in the cycle where a result is due. The directed checks count edges explicitly against these latencies, including the exact time-out edge and the single-clock gate response.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

  localparam int NSRC = 7;

  // Cause indices; a lower index is more urgent
  localparam int S_LINE  = 0;
  localparam int S_RXD   = 1;
  localparam int S_TOUT  = 2;
  localparam int S_THRE  = 3;
  localparam int S_MODEM = 4;
  localparam int S_RXTC  = 5;
  localparam int S_TXTC  = 6;

  typedef enum logic [3:0] {
    ID_MODEM = 4'b0000,
    ID_NONE  = 4'b0001,
    ID_THRE  = 4'b0010,
    ID_RXD   = 4'b0100,
    ID_LINE  = 4'b0110,
    ID_RXTC  = 4'b1000,
    ID_TXTC  = 4'b1010,
    ID_TOUT  = 4'b1100
  } irq_id_e;

  function automatic irq_id_e src_code(input int idx);
    case (idx)
      S_LINE:  return ID_LINE;
      S_RXD:   return ID_RXD;
      S_TOUT:  return ID_TOUT;
      S_THRE:  return ID_THRE;
      S_MODEM: return ID_MODEM;
      S_RXTC:  return ID_RXTC;
      S_TXTC:  return ID_TXTC;
      default: return ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
`timescale 1ns/1ps
module uart_irq_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);

  logic [W-1:0] flag_q;
  logic [W-1:0] flag_d;
  logic         flag_en;

  // A new event outranks a clear in the same cycle
  always_comb begin
    flag_d  = set_i | (flag_q & ~clr_i);
    flag_en = (|set_i) | (|(flag_q & clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flags_o = flag_q;

  // R3: an event always lands in its flag
  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  // R6 / R7 / R8: clear without a concurrent event empties the flag
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/uart_irq_timeout.sv
`timescale 1ns/1ps
module uart_irq_timeout #(
  parameter int CHAR_CYCLES = 16,
  parameter int TO_CHARS    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic nonempty,
  input  logic char_in,
  input  logic rd_rx,
  output logic tout_o
);

  localparam int LIMIT = CHAR_CYCLES * TO_CHARS;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tout_q, tout_d;
  logic          idle;
  logic          hit;

  always_comb begin
    idle  = fifo_mode & nonempty & ~char_in & ~rd_rx;
    hit   = idle && (cnt_q == LAST_V);
    if (!idle)               cnt_d = '0;
    else if (cnt_q == LIM_V) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
    if (rd_rx || !fifo_mode) tout_d = 1'b0;
    else                     tout_d = tout_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tout_q <= 1'b0;
    end else begin
      if (cnt_d != cnt_q)   cnt_q  <= cnt_d;
      if (tout_d != tout_q) tout_q <= tout_d;
    end
  end

  assign tout_o = tout_q;

  // R11: time-out appears only once the idle window is complete
  a_r11_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout_o) |-> (cnt_q == LIM_V));

  // R11: a data read removes the time-out
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx |=> !tout_o);

  // R9: no time-out in byte mode
  a_r9_fifo_only: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !tout_o);

endmodule

// File: rtl/uart_irq_thre.sv
`timescale 1ns/1ps
module uart_irq_thre (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty,
  input  logic wr_tx,
  input  logic rd_id_hit,
  output logic pend_o
);

  logic prev_q;
  logic pend_q, pend_d;
  logic rise;

  always_comb begin
    rise   = tx_empty & ~prev_q;
    pend_d = rise | (pend_q & ~(wr_tx | rd_id_hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (prev_q != tx_empty) prev_q <= tx_empty;
      if (pend_q != pend_d)   pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R10: a write while still full leaves nothing pending
  a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && !tx_empty) |=> !pend_o);

  // R10: pending only begins after the empty level is seen
  a_r10_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> $past(tx_empty));

endmodule

// File: rtl/uart_irq_arbiter.sv
`timescale 1ns/1ps
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [3:0]   code_o
);

  logic [N:0]   ahead;
  logic [N-1:0] grant;

  assign ahead[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_rank
      assign grant[g]   = req_i[g] & ~ahead[g];
      assign ahead[g+1] = ahead[g] | req_i[g];
    end
  endgenerate

  always_comb begin
    code_o = ID_NONE;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code_o = src_code(i);
    end
    any_o = ahead[N];
  end

  // R4: at most one cause is granted
  a_r4_single_grant: assert property (@(req_i) 1'b1 |-> $onehot0(grant))
    else ;

endmodule

// File: rtl/uart_irq_prioritizer.sv
`timescale 1ns/1ps
module uart_irq_prioritizer
  import uart_irq_pkg::*;
#(
  parameter int CHAR_CYCLES = 16,
  parameter int TO_CHARS    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       master_en,
  input  logic       en_line,
  input  logic       en_rx_data,
  input  logic       en_tx_empty,
  input  logic       en_modem,
  input  logic       en_rx_tc,
  input  logic       en_tx_tc,
  input  logic       ln_break,
  input  logic       ln_frame,
  input  logic       ln_parity,
  input  logic       ln_overrun,
  input  logic       ms_dcd,
  input  logic       ms_teri,
  input  logic       ms_dsr,
  input  logic       ms_cts,
  input  logic       rd_line,
  input  logic       rd_modem,
  input  logic       rx_ready,
  input  logic       rx_level_hit,
  input  logic       rx_fifo_nonempty,
  input  logic       rx_char_in,
  input  logic       rd_rx,
  input  logic       tx_empty,
  input  logic       wr_tx,
  input  logic       rd_id,
  input  logic       tc_rx_ev,
  input  logic       tc_tx_ev,
  input  logic       tc_wr,
  input  logic [1:0] tc_clr,
  output logic       irq,
  output logic [3:0] irq_id,
  output logic [3:0] line_flags,
  output logic [3:0] modem_flags,
  output logic [1:0] tc_flags
);

  localparam int LW = 4;
  localparam int MW = 4;
  localparam int TW = 2;

  // Reset synchronizer: asserts at once, releases on the clock
  logic rs_meta_q, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  logic [LW-1:0] line_set, line_clr;
  logic [MW-1:0] mdm_set, mdm_clr;
  logic [TW-1:0] tc_set, tc_clr_m;
  logic          tout_pend;
  logic          thre_pend;
  logic          thre_read;
  logic [NSRC-1:0] req;
  logic          any_req;
  logic [3:0]    code;
  logic          irq_q, irq_d;
  logic [3:0]    id_q;

  always_comb begin
    line_set = {ln_break, ln_frame, ln_parity, ln_overrun};
    line_clr = {LW{rd_line}};
    mdm_set  = {ms_dcd, ms_teri, ms_dsr, ms_cts};
    mdm_clr  = {MW{rd_modem}};
    tc_set   = {tc_tx_ev, tc_rx_ev};
    tc_clr_m = tc_wr ? tc_clr : '0;
    thre_read = rd_id && (id_q == ID_THRE);
  end

  uart_irq_sticky #(.W(LW)) u_line (
    .clk(clk), .rst_n(rs_q), .set_i(line_set), .clr_i(line_clr), .flags_o(line_flags));

  uart_irq_sticky #(.W(MW)) u_modem (
    .clk(clk), .rst_n(rs_q), .set_i(mdm_set), .clr_i(mdm_clr), .flags_o(modem_flags));

  uart_irq_sticky #(.W(TW)) u_tc (
    .clk(clk), .rst_n(rs_q), .set_i(tc_set), .clr_i(tc_clr_m), .flags_o(tc_flags));

  uart_irq_timeout #(.CHAR_CYCLES(CHAR_CYCLES), .TO_CHARS(TO_CHARS)) u_tout (
    .clk(clk), .rst_n(rs_q), .fifo_mode(fifo_mode), .nonempty(rx_fifo_nonempty),
    .char_in(rx_char_in), .rd_rx(rd_rx), .tout_o(tout_pend));

  uart_irq_thre u_thre (
    .clk(clk), .rst_n(rs_q), .tx_empty(tx_empty), .wr_tx(wr_tx),
    .rd_id_hit(thre_read), .pend_o(thre_pend));

  // Enabled cause vector, index order is the priority order
  always_comb begin
    req          = '0;
    req[S_LINE]  = en_line     & (|line_flags);
    req[S_RXD]   = en_rx_data  & (fifo_mode ? rx_level_hit : rx_ready);
    req[S_TOUT]  = en_rx_data  & tout_pend;
    req[S_THRE]  = en_tx_empty & thre_pend;
    req[S_MODEM] = en_modem    & (|modem_flags);
    req[S_RXTC]  = en_rx_tc    & tc_flags[0];
    req[S_TXTC]  = en_tx_tc    & tc_flags[1];
  end

  uart_irq_arbiter #(.N(NSRC)) u_arb (
    .req_i(req), .any_o(any_req), .code_o(code));

  assign irq_d = master_en & any_req;

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      irq_q <= 1'b0;
      id_q  <= ID_NONE;
    end else begin
      if (irq_q != irq_d) irq_q <= irq_d;
      if (id_q != code)   id_q  <= code;
    end
  end

  assign irq    = irq_q;
  assign irq_id = id_q;

  // R2: master gate closed means no request one clock later
  a_r2_master_gate: assert property (@(posedge clk) disable iff (!rs_q)
    !master_en |=> !irq);

  // R4: a raised request always carries a real cause code
  a_r4_id_matches_irq: assert property (@(posedge clk) disable iff (!rs_q)
    irq |-> !irq_id[0]);

  // R12: a new request follows a gate that was open on the previous edge
  a_r12_one_clock: assert property (@(posedge clk) disable iff (!rs_q)
    $rose(irq) |-> $past(master_en));

endmodule

// File: tb/tb_uart_irq_prioritizer.sv
`timescale 1ns/1ps
module tb_uart_irq_prioritizer;

  localparam int CC  = 4;
  localparam int TC  = 4;
  localparam int LIM = CC * TC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 0, master_en = 0;
  logic en_line = 0, en_rx_data = 0, en_tx_empty = 0, en_modem = 0, en_rx_tc = 0, en_tx_tc = 0;
  logic ln_break = 0, ln_frame = 0, ln_parity = 0, ln_overrun = 0;
  logic ms_dcd = 0, ms_teri = 0, ms_dsr = 0, ms_cts = 0;
  logic rd_line = 0, rd_modem = 0, rx_ready = 0, rx_level_hit = 0;
  logic rx_fifo_nonempty = 0, rx_char_in = 0, rd_rx = 0;
  logic tx_empty = 0, wr_tx = 0, rd_id = 0;
  logic tc_rx_ev = 0, tc_tx_ev = 0, tc_wr = 0;
  logic [1:0] tc_clr = 0;
  logic irq;
  logic [3:0] irq_id, line_flags, modem_flags;
  logic [1:0] tc_flags;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_irq_prioritizer #(.CHAR_CYCLES(CC), .TO_CHARS(TC)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .master_en(master_en),
    .en_line(en_line), .en_rx_data(en_rx_data), .en_tx_empty(en_tx_empty),
    .en_modem(en_modem), .en_rx_tc(en_rx_tc), .en_tx_tc(en_tx_tc),
    .ln_break(ln_break), .ln_frame(ln_frame), .ln_parity(ln_parity), .ln_overrun(ln_overrun),
    .ms_dcd(ms_dcd), .ms_teri(ms_teri), .ms_dsr(ms_dsr), .ms_cts(ms_cts),
    .rd_line(rd_line), .rd_modem(rd_modem), .rx_ready(rx_ready), .rx_level_hit(rx_level_hit),
    .rx_fifo_nonempty(rx_fifo_nonempty), .rx_char_in(rx_char_in), .rd_rx(rd_rx),
    .tx_empty(tx_empty), .wr_tx(wr_tx), .rd_id(rd_id),
    .tc_rx_ev(tc_rx_ev), .tc_tx_ev(tc_tx_ev), .tc_wr(tc_wr), .tc_clr(tc_clr),
    .irq(irq), .irq_id(irq_id), .line_flags(line_flags),
    .modem_flags(modem_flags), .tc_flags(tc_flags));

  // ---------------- behavioural reference model ----------------
  int   m_rel = 0;
  bit   m_live = 0;
  logic [3:0] m_line, m_mdm, m_id;
  logic [1:0] m_tc;
  logic m_irq, m_prev, m_thre, m_to;
  int   m_idle;

  function automatic logic [3:0] code_of(input int k);
    case (k)
      0: return 4'b0110;
      1: return 4'b0100;
      2: return 4'b1100;
      3: return 4'b0010;
      4: return 4'b0000;
      5: return 4'b1000;
      default: return 4'b1010;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n || m_rel < 2) begin
      if (rst_n) m_rel = m_rel + 1; else m_rel = 0;
      m_line = 0; m_mdm = 0; m_tc = 0; m_id = 4'b0001; m_irq = 0;
      m_prev = 0; m_thre = 0; m_to = 0; m_idle = 0;
    end else begin
      bit pend [7];
      logic [3:0] n_id;
      bit n_any, idle_now, n_to, n_thre;
      pend[0] = en_line && (m_line != 0);
      pend[1] = en_rx_data && (fifo_mode ? rx_level_hit : rx_ready);
      pend[2] = en_rx_data && m_to;
      pend[3] = en_tx_empty && m_thre;
      pend[4] = en_modem && (m_mdm != 0);
      pend[5] = en_rx_tc && m_tc[0];
      pend[6] = en_tx_tc && m_tc[1];
      n_id = 4'b0001; n_any = 0;
      for (int k = 6; k >= 0; k--) if (pend[k]) begin n_id = code_of(k); n_any = 1; end
      idle_now = fifo_mode && rx_fifo_nonempty && !rx_char_in && !rd_rx;
      n_to = m_to;
      if (idle_now) begin
        if (m_idle == LIM - 1) n_to = 1;
        if (m_idle < LIM) m_idle = m_idle + 1;
      end else m_idle = 0;
      if (rd_rx || !fifo_mode) n_to = 0;
      n_thre = (tx_empty && !m_prev) ||
               (m_thre && !wr_tx && !(rd_id && m_id == 4'b0010));
      m_prev = tx_empty;
      m_thre = n_thre;
      m_to   = n_to;
      if (rd_line) m_line = 0;
      m_line = m_line | {ln_break, ln_frame, ln_parity, ln_overrun};
      if (rd_modem) m_mdm = 0;
      m_mdm = m_mdm | {ms_dcd, ms_teri, ms_dsr, ms_cts};
      if (tc_wr) m_tc = m_tc & ~tc_clr;
      m_tc = m_tc | {tc_tx_ev, tc_rx_ev};
      m_id  = n_id;
      m_irq = master_en && n_any;
    end
    m_live = 1;
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (m_live && !finished) begin
      chk({7'd0, irq}, {7'd0, m_irq}, "R2 irq vs model");
      chk({4'd0, irq_id}, {4'd0, m_id}, "R4 irq_id vs model");
      chk({4'd0, line_flags}, {4'd0, m_line}, "R6 line_flags vs model");
      chk({4'd0, modem_flags}, {4'd0, m_mdm}, "R7 modem_flags vs model");
      chk({6'd0, tc_flags}, {6'd0, m_tc}, "R8 tc_flags vs model");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; step(1); s = 0;
  endtask

  task automatic clear_all();
    rx_level_hit = 0; rx_fifo_nonempty = 0; tx_empty = 0; rx_ready = 0;
    rd_line = 1; rd_modem = 1; rd_rx = 1; wr_tx = 1; tc_wr = 1; tc_clr = 2'b11;
    step(1);
    rd_line = 0; rd_modem = 0; rd_rx = 0; wr_tx = 0; tc_wr = 0; tc_clr = 0;
    step(2);
  endtask

  task automatic raise(input int k);
    case (k)
      0: pulse(ln_break);
      1: rx_level_hit = 1;
      2: begin rx_fifo_nonempty = 1; step(LIM + 1); end
      3: begin tx_empty = 1; step(1); end
      4: pulse(ms_dcd);
      5: pulse(tc_rx_ev);
      default: pulse(tc_tx_ev);
    endcase
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    step(3);
    rst_n = 1;
    step(4);
    // R1 reset state
    chk({7'd0, irq}, 8'd0, "R1 irq after reset");
    chk({4'd0, irq_id}, 8'h01, "R1 irq_id after reset");
    chk({2'd0, line_flags, tc_flags}, 8'd0, "R1 flags after reset");

    // R3 / R6 / R2: status captured with everything disabled
    pulse(ln_parity); step(1);
    chk({4'd0, line_flags}, 8'h02, "R3 parity flag while disabled");
    chk({4'd0, irq_id}, 8'h01, "R6 disabled line cause not reported");
    en_line = 1; step(1);
    chk({4'd0, irq_id}, 8'h06, "R6 line cause reported");
    chk({7'd0, irq}, 8'd0, "R2 irq held low by master gate");
    master_en = 1; step(1);
    chk({7'd0, irq}, 8'd1, "R12 irq one clock after gate opens");
    master_en = 0; step(1);
    chk({7'd0, irq}, 8'd0, "R12 irq one clock after gate closes");
    chk({4'd0, irq_id}, 8'h06, "R2 id still reports with gate closed");
    master_en = 1;
    pulse(rd_line); step(1);
    chk({4'd0, line_flags}, 8'd0, "R6 read clears line flags");
    chk({7'd0, irq}, 8'd0, "R6 irq drops after line read");
    // R6: event in the same cycle as the read survives
    rd_line = 1; ln_overrun = 1; step(1); rd_line = 0; ln_overrun = 0; step(1);
    chk({4'd0, line_flags}, 8'h01, "R6 concurrent event beats read");
    pulse(rd_line); step(1);

    // R7 modem
    en_modem = 1;
    pulse(ms_teri); step(1);
    chk({4'd0, modem_flags}, 8'h04, "R7 ring trailing edge flag");
    chk({4'd0, irq_id}, 8'h00, "R7 modem code");
    pulse(rd_modem); step(1);
    chk({4'd0, irq_id}, 8'h01, "R7 cleared by modem read");

    // R8 terminal counts
    en_tx_tc = 1;
    pulse(tc_rx_ev); step(1);
    chk({6'd0, tc_flags}, 8'h01, "R8 rx tc flag while its enable off");
    chk({4'd0, irq_id}, 8'h01, "R8 rx tc not reported when disabled");
    pulse(tc_tx_ev); step(1);
    chk({4'd0, irq_id}, 8'h0A, "R8 tx tc code");
    tc_wr = 1; tc_clr = 2'b01; step(1); tc_wr = 0; tc_clr = 0; step(1);
    chk({6'd0, tc_flags}, 8'h02, "R8 clear only masked bit");
    en_rx_tc = 1; tc_wr = 1; tc_clr = 2'b10; step(1); tc_wr = 0; tc_clr = 0; step(1);
    chk({6'd0, tc_flags}, 8'h00, "R8 clear tx bit");

    // R9 mode select for received data
    en_rx_data = 1; fifo_mode = 0; rx_level_hit = 1; step(2);
    chk({4'd0, irq_id}, 8'h01, "R9 level hit ignored in byte mode");
    rx_ready = 1; step(1);
    chk({4'd0, irq_id}, 8'h04, "R9 data ready in byte mode");
    fifo_mode = 1; rx_level_hit = 0; step(1);
    chk({4'd0, irq_id}, 8'h01, "R9 data ready ignored in fifo mode");
    rx_level_hit = 1; step(1);
    chk({4'd0, irq_id}, 8'h04, "R9 trigger level in fifo mode");
    rx_level_hit = 0; rx_ready = 0; step(1);

    // R11 exact time-out timing
    rx_fifo_nonempty = 1; step(LIM);
    chk({4'd0, irq_id}, 8'h01, "R11 no time-out before window ends");
    step(1);
    chk({4'd0, irq_id}, 8'h0C, "R11 time-out reported");
    pulse(rd_rx); step(1);
    chk({4'd0, irq_id}, 8'h01, "R11 read clears time-out");
    // R5 shared enable
    en_rx_data = 0; step(LIM + 3);
    chk({4'd0, irq_id}, 8'h01, "R5 time-out gated by rx data enable");
    en_rx_data = 1; step(1);
    chk({4'd0, irq_id}, 8'h0C, "R5 time-out shown once enabled");
    fifo_mode = 0; step(2);
    chk({4'd0, irq_id}, 8'h01, "R9 time-out dropped in byte mode");
    fifo_mode = 1; rx_fifo_nonempty = 0; step(1);

    // R10 transmitter empty
    en_tx_empty = 1; tx_empty = 1; step(2);
    chk({4'd0, irq_id}, 8'h02, "R10 tx empty reported");
    pulse(rd_id); step(1);
    chk({4'd0, irq_id}, 8'h01, "R10 cleared by id read");
    tx_empty = 0; step(1); tx_empty = 1; step(2);
    chk({4'd0, irq_id}, 8'h02, "R10 reported again on new edge");
    pulse(wr_tx); step(1);
    chk({4'd0, irq_id}, 8'h01, "R10 cleared by holding write");
    tx_empty = 0; step(1);

    // R4 every pair of simultaneous causes
    en_line = 1; en_rx_data = 1; en_tx_empty = 1; en_modem = 1; en_rx_tc = 1; en_tx_tc = 1;
    for (int i = 0; i < 7; i++) begin
      for (int j = i + 1; j < 7; j++) begin
        clear_all();
        raise(j); raise(i); step(2);
        chk({4'd0, irq_id}, {4'd0, code_of(i)}, $sformatf("R4 pair %0d/%0d", i, j));
        chk({7'd0, irq}, 8'd1, "R2 irq with enabled pair");
      end
    end
    clear_all();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R1: watchdog expired, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule